// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from three kinds of origin: pins watched for an active edge whose polarity software picks, a keyboard-style group of port pins that fires when their combined level drops, and single-cycle event pulses from other on-chip logic. Every source owns a request flag and an enable flag. A global disable flag sits above all of them. A non-maskable software-break request and the power-on reset vector are also handled here.

Request flags are grouped in pairs into vector slots. Request bit `i` belongs to slot `i/2`. A per-slot select bit decides which member of the pair the slot serves. With an odd source count, the last slot holds a single source. The slot index sets the priority, and each slot has a fixed vector address. The winning vector leaves on a valid/ready channel. A handshake on that channel is the interrupt acknowledge: it sets the global disable flag and clears only the flag that was presented.

Software reaches the flags through a small register bus, described by address:

- **Address 0**: request flags.
- **Address 1**: enable flags.
- **Address 2**: polarity bits in `[N_EXT-1:0]` and slot select bits in `[REG_W/2 +: NSLOT]`.
- **Address 3**: the global disable flag in bit 0.

Top module: `vec_intc`

## Requirements
- R1: After reset, the request and enable registers read 0, address 2 reads 0 (all polarities falling, all selects 0), the disable flag reads 1, and `vec_valid` is 1 with `vec_data` = 0xFFFC, the reset vector.
- R2: A maskable slot is offered only when the selected source's request bit and enable bit are both 1 and the disable flag is 0.
- R3: A write to address 0 clears every request bit written as 0 and leaves every bit written as 1 unchanged. It never sets a bit.
- R4: A hardware event on a source sets its request bit even when a software clear or an acknowledge clear of that bit falls in the same cycle.
- R5: Edge pin `j` is active on a rising edge when polarity bit `j` = 1 and on a falling edge when it is 0. Rewriting the polarity so that the pin now stands at its newly active level counts as an edge and sets the request bit.
- R6: The key source is request bit `N_EXT`. It is set when the AND of all key pins drops from 1 to 0, where a pin whose direction bit is 1 (output) is read as 1.
- R7: Request bits are ordered {event pulses, key, edge pins} from MSB to LSB. Slot `k` serves bit `2k` when its select bit is 0 and bit `2k+1` when it is 1. An unselected source still latches its request but is never offered.
- R8: Priority is fixed, highest first: reset vector (0xFFFC), then slot 0 down to slot NSLOT-1 (vector 0xFFFA-2k), then break. The break vector is 0xFFFA-2*NSLOT, which is 0xFFEC by default.
- R9: On a handshake (`vec_valid` and `vec_ready` both 1), the disable flag becomes 1, winning over a same-cycle register write. Only the presented request (slot flag, reset pending or break pending) is cleared, and all other requests stay pending.
- R10: The reset vector and the break request ignore the disable flag and all enable bits.
- R11: `vec_valid`/`vec_data` show the current winner every cycle. While `vec_ready` is 0 nothing is consumed. A higher request may replace the offered vector, and a software clear may withdraw it, before the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | N_EXT | Edge-detected request pins (synchronous to clk) |
| key_pin | input | KEY_W | Key group pin levels |
| key_dir | input | KEY_W | Key group direction, 1 = output (masked) |
| evt_pulse | input | N_INT | Internal single-cycle event pulses |
| brk_pulse | input | 1 | Software break request pulse |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |
| vec_valid | output | 1 | A vector is offered |
| vec_ready | input | 1 | Acknowledge: the CPU takes the vector |
| vec_data | output | VEC_W | Offered vector address |

## Verification
The bench builds the block with its default parameters: three edge pins, eight key pins and nine event pulses. That gives thirteen sources in seven slots, so the last slot holds a single source and its select bit has no effect, and the break vector lands at 0xFFEC. With thirteen request bits, every pairing, the unpaired slot and the full descending vector ladder can be reached. Random polarity rewrites alongside moving pins bring the polarity-induced requests within reach.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_RST  = 2'd1,
    WIN_SLOT = 2'd2,
    WIN_BRK  = 2'd3
  } win_e;

  localparam logic [1:0] ADDR_REQ  = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_DIS  = 2'd3;
endpackage

// File: rtl/vec_intc_edge.sv
module vec_intc_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic lvl;
    logic lvl_q;
    // active level normalised to 1; a change of pol can create a rise
    assign lvl = ~(pin[i] ^ pol[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b1;
      else        lvl_q <= lvl;
    end
    assign hit[i] = lvl & ~lvl_q;
  end
endmodule

// File: rtl/vec_intc_key.sv
module vec_intc_key #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] dir,
  output logic         hit
);
  logic low;
  logic low_q;
  // output-configured pins are forced high before the AND
  assign low = ~(&(pin | dir));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b1;
    else        low_q <= low;
  end
  assign hit = low & ~low_q;
endmodule

// File: rtl/vec_intc_flags.sv
module vec_intc_flags #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         wr_req,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] req,
  output logic [N-1:0] en
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 req[i] <= 1'b0;
      else if (hw_set[i])                         req[i] <= 1'b1;
      else if ((wr_req && !wdata[i]) || ack_clr[i]) req[i] <= 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en[i] <= 1'b0;
      else if (wr_en) en[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb
  import vec_intc_pkg::*;
#(
  parameter int                N_SRC     = 13,
  parameter int                NSLOT     = 7,
  parameter int                VEC_W     = 16,
  parameter logic [VEC_W-1:0]  VEC_RESET = 16'hFFFC
) (
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] en,
  input  logic [NSLOT-1:0] sel,
  input  logic             dis,
  input  logic             rst_pend,
  input  logic             brk_pend,
  output logic             valid,
  output logic [VEC_W-1:0] vec,
  output win_e             kind,
  output logic [N_SRC-1:0] clr_mask
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [VEC_W-1:0] VEC_BRK = VEC_RESET - VEC_W'(2 * (NSLOT + 1));

  logic [N_SRC-1:0] pick_mask [NSLOT];
  logic [NSLOT-1:0] slot_hit;
  logic [SW-1:0]    win_slot;
  logic             found;
  logic             unused_sel;

  assign unused_sel = ^sel;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (2 * k + 1 < N_SRC) begin : g_pair
      assign pick_mask[k] = sel[k] ? (N_SRC'(1) << (2 * k + 1)) : (N_SRC'(1) << (2 * k));
    end else begin : g_single
      assign pick_mask[k] = N_SRC'(1) << (2 * k);
    end
    assign slot_hit[k] = |(pick_mask[k] & req & en);
  end

  always_comb begin
    found    = 1'b0;
    win_slot = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (slot_hit[k]) begin
        found    = 1'b1;
        win_slot = SW'(k);
      end
    end
  end

  always_comb begin
    if (rst_pend)            kind = WIN_RST;
    else if (found && !dis)  kind = WIN_SLOT;
    else if (brk_pend)       kind = WIN_BRK;
    else                     kind = WIN_NONE;
  end

  always_comb begin
    unique case (kind)
      WIN_RST:  vec = VEC_RESET;
      WIN_SLOT: vec = VEC_RESET - (VEC_W'(win_slot) << 1) - VEC_W'(2);
      WIN_BRK:  vec = VEC_BRK;
      default:  vec = '0;
    endcase
  end

  assign valid    = (kind != WIN_NONE);
  assign clr_mask = (kind == WIN_SLOT) ? pick_mask[win_slot] : '0;
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int               N_EXT     = 3,
  parameter int               KEY_W     = 8,
  parameter int               N_INT     = 9,
  parameter int               REG_W     = 16,
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] VEC_RESET = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [KEY_W-1:0] key_pin,
  input  logic [KEY_W-1:0] key_dir,
  input  logic [N_INT-1:0] evt_pulse,
  input  logic             brk_pulse,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec_data
);
  localparam int N_SRC   = N_EXT + 1 + N_INT;
  localparam int NSLOT   = (N_SRC + 1) / 2;
  localparam int SEL_LSB = REG_W / 2;

  logic [N_EXT-1:0] pol_q;
  logic [NSLOT-1:0] sel_q;
  logic             dis_q;
  logic             rst_pend_q;
  logic             brk_pend_q;
  logic [N_EXT-1:0] ext_hit;
  logic             key_hit;
  logic [N_SRC-1:0] hw_set;
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] clr_mask;
  logic [N_SRC-1:0] ack_clr;
  win_e             kind;
  logic             hs;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  vec_intc_edge #(.W(N_EXT)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .pol(pol_q), .hit(ext_hit)
  );

  vec_intc_key #(.W(KEY_W)) u_key (
    .clk(clk), .rst_n(rst_n), .pin(key_pin), .dir(key_dir), .hit(key_hit)
  );

  assign hw_set  = {evt_pulse, key_hit, ext_hit};
  assign hs      = vec_valid & vec_ready;
  assign ack_clr = (hs && kind == WIN_SLOT) ? clr_mask : '0;

  vec_intc_flags #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
    .wr_req(reg_wr && reg_addr == ADDR_REQ),
    .wr_en(reg_wr && reg_addr == ADDR_EN),
    .wdata(reg_wdata[N_SRC-1:0]), .ack_clr(ack_clr),
    .req(req_q), .en(en_q)
  );

  vec_intc_arb #(
    .N_SRC(N_SRC), .NSLOT(NSLOT), .VEC_W(VEC_W), .VEC_RESET(VEC_RESET)
  ) u_arb (
    .req(req_q), .en(en_q), .sel(sel_q), .dis(dis_q),
    .rst_pend(rst_pend_q), .brk_pend(brk_pend_q),
    .valid(vec_valid), .vec(vec_data), .kind(kind), .clr_mask(clr_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      sel_q <= '0;
    end else if (reg_wr && reg_addr == ADDR_CTRL) begin
      pol_q <= reg_wdata[N_EXT-1:0];
      sel_q <= reg_wdata[SEL_LSB +: NSLOT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             dis_q <= 1'b1;
    else if (hs)                            dis_q <= 1'b1;
    else if (reg_wr && reg_addr == ADDR_DIS) dis_q <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rst_pend_q <= 1'b1;
    else if (hs && kind == WIN_RST)    rst_pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        brk_pend_q <= 1'b0;
    else if (brk_pulse)                brk_pend_q <= 1'b1;
    else if (hs && kind == WIN_BRK)    brk_pend_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_REQ:  reg_rdata[N_SRC-1:0] = req_q;
      ADDR_EN:   reg_rdata[N_SRC-1:0] = en_q;
      ADDR_CTRL: begin
        reg_rdata[N_EXT-1:0]        = pol_q;
        reg_rdata[SEL_LSB +: NSLOT] = sel_q;
      end
      default:   reg_rdata[0] = dis_q;
    endcase
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int               N_SRC     = 13,
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] VEC_RESET = 16'hFFFC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [VEC_W-1:0] vec_data,
  input logic [N_SRC-1:0] req_q,
  input logic [N_SRC-1:0] hw_set,
  input logic             dis_q,
  input logic             rst_pend_q,
  input logic             brk_pend_q
);
  // R3
  req_only_hw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~$past(req_q) & ~$past(hw_set)) == '0));

  // R9
  ack_sets_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> dis_q);

  // R2
  masked_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !rst_pend_q && !brk_pend_q) |-> !vec_valid);

  // R8
  vector_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_data[0] == 1'b0 && vec_data <= VEC_RESET));

  // R10
  brk_never_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pend_q |-> vec_valid);
endmodule

bind vec_intc vec_intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_RESET(VEC_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .vec_data(vec_data), .req_q(req_q), .hw_set(hw_set), .dis_q(dis_q),
  .rst_pend_q(rst_pend_q), .brk_pend_q(brk_pend_q)
);

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
  localparam int N_EXT = 3;
  localparam int KEY_W = 8;
  localparam int N_INT = 9;
  localparam int N_SRC = 13;
  localparam int NSLOT = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_EXT-1:0] ext_pin = '1;
  logic [KEY_W-1:0] key_pin = '1;
  logic [KEY_W-1:0] key_dir = '0;
  logic [N_INT-1:0] evt_pulse = '0;
  logic             brk_pulse = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic [15:0]      reg_wdata = '0;
  logic [15:0]      reg_rdata;
  logic             vec_valid;
  logic             vec_ready = 1'b0;
  logic [15:0]      vec_data;

  int checks = 0;
  int fails = 0;

  // bench-side expected state
  logic [N_SRC-1:0] m_req, m_en;
  logic [N_EXT-1:0] m_pol, m_lvlq;
  logic [NSLOT-1:0] m_sel;
  logic m_dis, m_rst, m_brk, m_keyq;

  always #4 clk = ~clk;

  vec_intc dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .key_pin(key_pin),
    .key_dir(key_dir), .evt_pulse(evt_pulse), .brk_pulse(brk_pulse),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_out(output bit v, output logic [15:0] d, output int kind, output int src);
    v = 0; d = '0; kind = 0; src = 0;
    if (m_rst) begin
      v = 1; d = 16'hFFFC; kind = 1;
    end else begin
      for (int k = 0; k < NSLOT; k++) begin
        int s;
        s = (2 * k + 1 < N_SRC && m_sel[k]) ? 2 * k + 1 : 2 * k;
        if (kind == 0 && !m_dis && m_req[s] && m_en[s]) begin
          v = 1; kind = 2; src = s; d = 16'(16'hFFFA - 2 * k);
        end
      end
      if (kind == 0 && m_brk) begin
        v = 1; kind = 3; d = 16'hFFEC;
      end
    end
  endtask

  task automatic step();
    bit v; logic [15:0] d; int kind, src; logic [15:0] er; bit hs;
    logic [N_EXT-1:0] lvl, hit; logic klow, khit; logic [N_SRC-1:0] hw;
    #1;
    model_out(v, d, kind, src);
    check("R8 vec_valid", {31'b0, vec_valid}, {31'b0, v});
    if (v) check("R8 vec_data", {16'b0, vec_data}, {16'b0, d});
    er = '0;
    case (reg_addr)
      2'd0: begin er[N_SRC-1:0] = m_req; check("R3 request reg", {16'b0, reg_rdata}, {16'b0, er}); end
      2'd1: begin er[N_SRC-1:0] = m_en;  check("R2 enable reg", {16'b0, reg_rdata}, {16'b0, er}); end
      2'd2: begin er[N_EXT-1:0] = m_pol; er[8 +: NSLOT] = m_sel;
                  check("R7 ctrl reg", {16'b0, reg_rdata}, {16'b0, er}); end
      default: begin er[0] = m_dis; check("R9 disable reg", {16'b0, reg_rdata}, {16'b0, er}); end
    endcase
    hs = v && vec_ready;
    lvl = ~(ext_pin ^ m_pol);
    hit = lvl & ~m_lvlq;
    m_lvlq = lvl;
    klow = ~(&(key_pin | key_dir));
    khit = klow & ~m_keyq;
    m_keyq = klow;
    hw = {evt_pulse, khit, hit};
    if (reg_wr && reg_addr == 2'd0) m_req = m_req & reg_wdata[N_SRC-1:0];
    if (hs && kind == 2) m_req[src] = 1'b0;
    m_req = m_req | hw;
    if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata[N_SRC-1:0];
    if (reg_wr && reg_addr == 2'd2) begin m_pol = reg_wdata[N_EXT-1:0]; m_sel = reg_wdata[8 +: NSLOT]; end
    if (hs) m_dis = 1'b1;
    else if (reg_wr && reg_addr == 2'd3) m_dis = reg_wdata[0];
    if (hs && kind == 1) m_rst = 1'b0;
    if (brk_pulse) m_brk = 1'b1;
    else if (hs && kind == 3) m_brk = 1'b0;
    @(negedge clk);
    evt_pulse = '0; brk_pulse = 1'b0; reg_wr = 1'b0; vec_ready = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] dat);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = dat;
    step();
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a; reg_wr = 1'b0;
    #1;
    check(tag, {16'b0, reg_rdata}, {16'b0, exp});
    step();
  endtask

  task automatic chk_vec(input bit v, input logic [15:0] d, input string tag);
    #1;
    check(tag, {31'b0, vec_valid}, {31'b0, v});
    if (v) check(tag, {16'b0, vec_data}, {16'b0, d});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_req = '0; m_en = '0; m_pol = '0; m_sel = '0; m_lvlq = '1;
    m_dis = 1'b1; m_rst = 1'b1; m_brk = 1'b0; m_keyq = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_vec(1, 16'hFFFC, "R1 reset vector");
    rd_chk(2'd0, 16'h0000, "R1 request reset");
    rd_chk(2'd1, 16'h0000, "R1 enable reset");
    rd_chk(2'd2, 16'h0000, "R1 ctrl reset");
    rd_chk(2'd3, 16'h0001, "R1 disable reset");
    // take the reset vector
    vec_ready = 1'b1; step();
    chk_vec(0, 16'h0, "R9 reset vector consumed");
    rd_chk(2'd3, 16'h0001, "R9 disable after ack");

    // R3 software cannot set
    wr(2'd0, 16'hFFFF);
    rd_chk(2'd0, 16'h0000, "R3 ones do not set");
    evt_pulse[0] = 1'b1; step();
    rd_chk(2'd0, 16'h0010, "R3 event bit4 set");
    wr(2'd0, 16'hFFFF);
    rd_chk(2'd0, 16'h0010, "R3 ones keep bit");
    wr(2'd0, 16'hFFEF);
    rd_chk(2'd0, 16'h0000, "R3 zero clears bit");

    // R4 set beats clear
    evt_pulse[0] = 1'b1; reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 16'h0000; step();
    rd_chk(2'd0, 16'h0010, "R4 set wins over clear");
    wr(2'd0, 16'h0000);

    // R5 edges and polarity change
    ext_pin[0] = 1'b0; step();
    rd_chk(2'd0, 16'h0001, "R5 falling edge");
    wr(2'd0, 16'h0000);
    ext_pin[0] = 1'b1; step(); step();
    rd_chk(2'd0, 16'h0000, "R5 rising ignored when falling chosen");
    wr(2'd2, 16'h0001);
    step();
    rd_chk(2'd0, 16'h0001, "R5 polarity change raises request");
    wr(2'd0, 16'h0000);
    ext_pin[0] = 1'b0; step();
    ext_pin[0] = 1'b1; step();
    rd_chk(2'd0, 16'h0001, "R5 rising edge");
    wr(2'd0, 16'h0000);

    // R6 key group
    key_dir = 8'h01; key_pin = 8'hFE; step(); step();
    rd_chk(2'd0, 16'h0000, "R6 output pin masked");
    key_pin = 8'hDE; step();
    rd_chk(2'd0, 16'h0008, "R6 key falling");
    key_pin = 8'hFF; key_dir = 8'h00;
    wr(2'd0, 16'h0000);

    // R7 / R8 slot sharing and priority
    wr(2'd1, 16'h1FFF);
    wr(2'd3, 16'h0000);
    chk_vec(0, 16'h0, "R2 nothing pending");
    ext_pin[1] = 1'b0; step();
    chk_vec(0, 16'h0, "R7 unselected source not offered");
    rd_chk(2'd0, 16'h0002, "R7 unselected still latched");
    wr(2'd2, 16'h0101);
    chk_vec(1, 16'hFFFA, "R7 alternate source selected");
    evt_pulse[0] = 1'b1; evt_pulse[8] = 1'b1; step();
    chk_vec(1, 16'hFFFA, "R8 slot0 beats slot2 and slot6");
    wr(2'd2, 16'h0001);
    chk_vec(1, 16'hFFF6, "R8 slot2 vector");
    vec_ready = 1'b1; step();
    chk_vec(0, 16'h0, "R9 disable set by ack");
    rd_chk(2'd0, 16'h1002, "R9 only winner cleared");
    wr(2'd3, 16'h0000);
    chk_vec(1, 16'hFFEE, "R8 single slot6 vector");
    step(); step();
    chk_vec(1, 16'hFFEE, "R11 held without ready");
    rd_chk(2'd0, 16'h1002, "R11 nothing consumed");

    // R10 break ignores masking
    wr(2'd3, 16'h0001);
    chk_vec(0, 16'h0, "R2 masked by disable");
    brk_pulse = 1'b1; step();
    chk_vec(1, 16'hFFEC, "R10 break offered while disabled");
    vec_ready = 1'b1; step();
    chk_vec(0, 16'h0, "R10 break consumed");
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0000);
    chk_vec(0, 16'h0, "R2 enable cleared");
    wr(2'd0, 16'h0000);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) ext_pin[$urandom_range(0, N_EXT - 1)] ^= 1'b1;
      key_pin = ($urandom_range(0, 9) == 0) ? ~(8'h01 << $urandom_range(0, 7)) : 8'hFF;
      if ($urandom_range(0, 19) == 0) key_dir = 8'($urandom_range(0, 255));
      for (int e = 0; e < N_INT; e++) evt_pulse[e] = ($urandom_range(0, 29) == 0);
      brk_pulse = ($urandom_range(0, 59) == 0);
      reg_addr = 2'($urandom_range(0, 3));
      reg_wr = ($urandom_range(0, 4) == 0);
      reg_wdata = 16'($urandom_range(0, 65535));
      if (reg_addr == 2'd3 && reg_wr) reg_wdata[0] = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
      vec_ready = ($urandom_range(0, 1) == 1);
      step();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule